// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank, 32-bit synchronous DRAM interface. On each rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable, the bank-select bits and the address bus. From these it works out which command the controller issued. It splits the address according to that command and returns the result on registered outputs one clock later.

The block also keeps, for every bank, an open flag and the row that was last opened. A read or write reports the row that is open in its target bank. Reads and writes start a burst of fixed length. If such a burst carries the auto-precharge request, its bank closes once the burst has run out, or earlier if a later read or write cuts the burst short. Deselected cycles issue no command and leave any running burst alone. Commands that break the bank rules raise a one-cycle illegal flag and change no state.

Top module: `sdrcmd_top`

## Requirements
- R1: `{cs_n, ras_n, cas_n, we_n}` decode to `cmd_o` one clock after sampling: 0011→1 (activate), 0101→2 (read), 0100→3 (write), 0010→4 (precharge), 0001→5 (refresh), 0000→6 (mode load), 0111 and 0110→0 (no-op).
- R2: With `cs_n` sampled high, `cmd_o` becomes 7 (deselect) whatever the other strobes are. Bank state is unchanged, and a running burst keeps counting.
- R3: A legal activate sets the open flag of bank `ba`, stores `addr` as that bank's row, and reports `addr` on `row_o` and `ba` on `bank_o`.
- R4: A read or write reports `addr[7:0]` on `col_o`, `addr[10]` on `auto_pre_o`, and the stored open row of the target bank on `row_o`.
- R5: A precharge with `addr[10]`=1 closes every bank and sets `pre_all_o`. With `addr[10]`=0 it closes only bank `ba` and clears `pre_all_o`.
- R6: A mode load copies `addr` to `mode_op_o`. The value holds until the next mode load.
- R7: `illegal_o` is set for a read or write to a closed bank, or for an activate to an open bank. An illegal activate leaves the stored row unchanged, and an illegal read or write starts no burst.
- R8: A legal read or write holds `burst_active_o` high for BURST_LEN cycles. A later legal read or write restarts the count.
- R9: A legal read or write with auto-precharge closes its bank on the clock edge that ends its burst, or on the edge of an interrupting legal read or write.
- R10: Reset closes all banks, ends any burst, and clears `cmd_o`, `illegal_o` and `mode_op_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 11 | Row, column, flag or opcode bits |
| cmd_o | output | 3 | Decoded command code (R1) |
| bank_o | output | 2 | Bank sampled with the command |
| row_o | output | 11 | Row opened, or open row being accessed |
| col_o | output | 8 | Column of a read or write |
| auto_pre_o | output | 1 | Auto-precharge requested |
| pre_all_o | output | 1 | Precharge targets every bank |
| mode_op_o | output | 11 | Last mode-load opcode |
| illegal_o | output | 1 | Command violated bank rules |
| bank_open_o | output | 4 | Per-bank open flags |
| burst_active_o | output | 1 | A read or write burst is running |

## Verification
The bench uses the default four banks, 11-bit address and 8-bit column, but sets BURST_LEN to 3. With that short burst, the auto-precharge close at the end of a burst and its early close on an interrupting access both fall inside a few deselect cycles. The odd length also shows up any off-by-one in the burst counter. The vector table walks every command code through open and closed banks. The rejected activate is followed by a read of the same bank, so the row that was kept shows on the ports.

// File: rtl/sdrcmd_pkg.sv
package sdrcmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_REF   = 3'd5,
    CMD_LMR   = 3'd6,
    CMD_DESEL = 3'd7
  } cmd_e;

  // Strobe pattern to command; chip select high masks everything.
  function automatic cmd_e strobe_decode(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_LMR;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdrcmd_decode.sv
module sdrcmd_decode
  import sdrcmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10
) (
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o,
  output logic              rdwr_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              flag10_o
);

  always_comb begin
    cmd_o    = strobe_decode(cs_n_i, ras_n_i, cas_n_i, we_n_i);
    rdwr_o   = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);
    row_o    = addr_i;
    col_o    = addr_i[COL_W-1:0];
    // Shared bit: auto-precharge on accesses, all-banks on precharge.
    flag10_o = addr_i[AP_BIT];
  end

endmodule

// File: rtl/sdrcmd_bank_state.sv
module sdrcmd_bank_state #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 11,
  localparam int NB    = 1 << BA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      set_v_i,
  input  logic [BA_W-1:0]           set_bank_i,
  input  logic [ADDR_W-1:0]         set_row_i,
  input  logic                      clr_v_i,
  input  logic                      clr_all_i,
  input  logic [BA_W-1:0]           clr_bank_i,
  input  logic                      ap_v_i,
  input  logic [BA_W-1:0]           ap_bank_i,
  output logic [NB-1:0]             open_o,
  output logic [NB-1:0][ADDR_W-1:0] rows_o
);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic hit_set, hit_clr;
    assign hit_set = set_v_i && (set_bank_i == BA_W'(g));
    assign hit_clr = (clr_v_i && (clr_all_i || (clr_bank_i == BA_W'(g)))) ||
                     (ap_v_i && (ap_bank_i == BA_W'(g)));

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        open_o[g] <= 1'b0;
        rows_o[g] <= '0;
      end else if (hit_set) begin
        // Opening only happens on a closed bank, so it outranks any close.
        open_o[g] <= 1'b1;
        rows_o[g] <= set_row_i;
      end else if (hit_clr) begin
        open_o[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdrcmd_burst.sv
module sdrcmd_burst #(
  parameter int BA_W      = 2,
  parameter int BURST_LEN = 4,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_v_i,
  input  logic [BA_W-1:0] start_bank_i,
  input  logic            start_ap_i,
  input  logic            pre_v_i,
  input  logic            pre_all_i,
  input  logic [BA_W-1:0] pre_bank_i,
  output logic            active_o,
  output logic            close_v_o,
  output logic [BA_W-1:0] close_bank_o
);

  logic [CNT_W-1:0] left_q;
  logic             ap_q;
  logic [BA_W-1:0]  ap_bank_q;
  logic             last_beat, pre_hits;

  assign active_o     = (left_q != '0);
  assign last_beat    = (left_q == CNT_W'(1));
  assign close_v_o    = ap_q && active_o && (last_beat || start_v_i);
  assign close_bank_o = ap_bank_q;
  assign pre_hits     = pre_v_i && (pre_all_i || (pre_bank_i == ap_bank_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_q    <= '0;
      ap_q      <= 1'b0;
      ap_bank_q <= '0;
    end else if (start_v_i) begin
      left_q    <= CNT_W'(BURST_LEN);
      ap_q      <= start_ap_i;
      ap_bank_q <= start_bank_i;
    end else begin
      if (active_o) left_q <= left_q - CNT_W'(1);
      // Pending close is dropped once done or once an explicit precharge did it.
      if (last_beat || pre_hits) ap_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdrcmd_top.sv
module sdrcmd_top
  import sdrcmd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 11,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  localparam int NB       = 1 << BA_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              auto_pre_o,
  output logic              pre_all_o,
  output logic [ADDR_W-1:0] mode_op_o,
  output logic              illegal_o,
  output logic [NB-1:0]     bank_open_o,
  output logic              burst_active_o
);

  cmd_e                      d_cmd;
  logic                      d_rdwr, d_flag10;
  logic [ADDR_W-1:0]         d_row;
  logic [COL_W-1:0]          d_col;
  logic [NB-1:0]             open_w;
  logic [NB-1:0][ADDR_W-1:0] rows_w;
  logic                      tgt_open, act_ok, access_ok, bad_cmd, is_pre;
  logic                      ap_close_v;
  logic [BA_W-1:0]           ap_close_bank;

  sdrcmd_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) dec_i (
    .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .addr_i(addr_i), .cmd_o(d_cmd), .rdwr_o(d_rdwr), .row_o(d_row),
    .col_o(d_col), .flag10_o(d_flag10)
  );

  always_comb begin
    tgt_open  = open_w[ba_i];
    is_pre    = (d_cmd == CMD_PRE);
    act_ok    = (d_cmd == CMD_ACT) && !tgt_open;
    access_ok = d_rdwr && tgt_open;
    bad_cmd   = ((d_cmd == CMD_ACT) && tgt_open) || (d_rdwr && !tgt_open);
  end

  sdrcmd_bank_state #(.BA_W(BA_W), .ADDR_W(ADDR_W)) banks_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .set_v_i(act_ok), .set_bank_i(ba_i), .set_row_i(d_row),
    .clr_v_i(is_pre), .clr_all_i(d_flag10), .clr_bank_i(ba_i),
    .ap_v_i(ap_close_v), .ap_bank_i(ap_close_bank),
    .open_o(open_w), .rows_o(rows_w)
  );

  sdrcmd_burst #(.BA_W(BA_W), .BURST_LEN(BURST_LEN)) burst_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .start_v_i(access_ok), .start_bank_i(ba_i), .start_ap_i(d_flag10),
    .pre_v_i(is_pre), .pre_all_i(d_flag10), .pre_bank_i(ba_i),
    .active_o(burst_active_o), .close_v_o(ap_close_v),
    .close_bank_o(ap_close_bank)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmd_o      <= CMD_NOP;
      bank_o     <= '0;
      row_o      <= '0;
      col_o      <= '0;
      auto_pre_o <= 1'b0;
      pre_all_o  <= 1'b0;
      mode_op_o  <= '0;
      illegal_o  <= 1'b0;
    end else begin
      cmd_o      <= d_cmd;
      bank_o     <= ba_i;
      col_o      <= d_rdwr ? d_col : '0;
      auto_pre_o <= d_rdwr && d_flag10;
      pre_all_o  <= is_pre && d_flag10;
      illegal_o  <= bad_cmd;
      if (d_cmd == CMD_LMR) mode_op_o <= d_row;
      unique case (d_cmd)
        CMD_ACT:        row_o <= d_row;
        CMD_RD, CMD_WR: row_o <= rows_w[ba_i];
        default:        row_o <= '0;
      endcase
    end
  end

  assign bank_open_o = open_w;

endmodule

// File: rtl/sdrcmd_checker.sv
module sdrcmd_checker #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 11,
  localparam int NB    = 1 << BA_W
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              cs_n_i,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2:0]        cmd_o,
  input logic [BA_W-1:0]   bank_o,
  input logic              pre_all_o,
  input logic [ADDR_W-1:0] mode_op_o,
  input logic              illegal_o,
  input logic [NB-1:0]     bank_open_o,
  input logic              burst_active_o
);

  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    cs_n_i |=> (cmd_o == 3'd7));

  assert_act_opens_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_o == 3'd1 && !illegal_o) |-> bank_open_o[bank_o]);

  assert_pre_all_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_o == 3'd4 && pre_all_o) |-> (bank_open_o == '0));

  assert_pre_one_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_o == 3'd4 && !pre_all_o) |-> !bank_open_o[bank_o]);

  assert_mode_copy_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cs_n_i && !ras_n_i && !cas_n_i && !we_n_i) |=> (mode_op_o == $past(addr_i)));

  assert_illegal_kind_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    illegal_o |-> (cmd_o == 3'd1 || cmd_o == 3'd2 || cmd_o == 3'd3));

  assert_burst_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    ((cmd_o == 3'd2 || cmd_o == 3'd3) && !illegal_o) |-> burst_active_o);

  assert_reset_clear_R10: assert property (@(posedge clk_i)
    rst_i |=> (bank_open_o == '0 && !burst_active_o && cmd_o == 3'd0));

endmodule

bind sdrcmd_top sdrcmd_checker #(.BA_W(BA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
  .cas_n_i(cas_n_i), .we_n_i(we_n_i), .addr_i(addr_i), .cmd_o(cmd_o),
  .bank_o(bank_o), .pre_all_o(pre_all_o), .mode_op_o(mode_op_o),
  .illegal_o(illegal_o), .bank_open_o(bank_open_o),
  .burst_active_o(burst_active_o)
);

// File: tb/sdrcmd_top_tb_top.sv
module sdrcmd_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BL         = 3;
  localparam int NVEC       = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [2:0]  cmd;
  logic [1:0]  bank;
  logic [10:0] row, mode_op;
  logic [7:0]  col;
  logic        auto_pre, pre_all, illegal, burst;
  logic [3:0]  open_m;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdrcmd_top #(.BURST_LEN(BL)) dut_i (
    .clk_i(clk), .rst_i(rst), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .ba_i(ba), .addr_i(addr), .cmd_o(cmd), .bank_o(bank),
    .row_o(row), .col_o(col), .auto_pre_o(auto_pre), .pre_all_o(pre_all),
    .mode_op_o(mode_op), .illegal_o(illegal), .bank_open_o(open_m),
    .burst_active_o(burst)
  );

  // {strobes4, ba2, addr11, cmd3, illegal1, open4, check_row1, row11}
  localparam logic [36:0] VEC [NVEC] = '{
    {4'b0111, 2'd0, 11'h000, 3'd0, 1'b0, 4'b0000, 1'b0, 11'h000},
    {4'b0011, 2'd1, 11'h2A5, 3'd1, 1'b0, 4'b0010, 1'b1, 11'h2A5},
    {4'b0011, 2'd3, 11'h7FF, 3'd1, 1'b0, 4'b1010, 1'b1, 11'h7FF},
    {4'b0101, 2'd1, 11'h013, 3'd2, 1'b0, 4'b1010, 1'b1, 11'h2A5},
    {4'b0100, 2'd3, 11'h0FE, 3'd3, 1'b0, 4'b1010, 1'b1, 11'h7FF},
    {4'b0101, 2'd0, 11'h033, 3'd2, 1'b1, 4'b1010, 1'b0, 11'h000},
    {4'b0011, 2'd1, 11'h111, 3'd1, 1'b1, 4'b1010, 1'b0, 11'h000},
    {4'b0101, 2'd1, 11'h020, 3'd2, 1'b0, 4'b1010, 1'b1, 11'h2A5},
    {4'b1011, 2'd2, 11'h3C0, 3'd7, 1'b0, 4'b1010, 1'b0, 11'h000},
    {4'b0110, 2'd0, 11'h000, 3'd0, 1'b0, 4'b1010, 1'b0, 11'h000},
    {4'b0001, 2'd0, 11'h000, 3'd5, 1'b0, 4'b1010, 1'b0, 11'h000},
    {4'b0010, 2'd1, 11'h3FF, 3'd4, 1'b0, 4'b1000, 1'b0, 11'h000},
    {4'b0011, 2'd0, 11'h400, 3'd1, 1'b0, 4'b1001, 1'b1, 11'h400},
    {4'b0010, 2'd2, 11'h400, 3'd4, 1'b0, 4'b0000, 1'b0, 11'h000},
    {4'b0100, 2'd2, 11'h005, 3'd3, 1'b1, 4'b0000, 1'b0, 11'h000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] code, input logic [1:0] b, input logic [10:0] a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = code;
    ba   = b;
    addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R10 cmd", 32'(cmd), 32'd0);
    check("R10 open", 32'(open_m), 32'd0);
    check("R10 burst", 32'(burst), 32'd0);
    check("R10 mode", 32'(mode_op), 32'd0);
    check("R10 illegal", 32'(illegal), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      automatic logic [36:0] v = VEC[i];
      drive(v[36:33], v[32:31], v[30:20]);
      check($sformatf("R1 cmd vec%0d", i), 32'(cmd), 32'(v[19:17]));
      check($sformatf("R7 illegal vec%0d", i), 32'(illegal), 32'(v[16]));
      check($sformatf("R3 R5 open vec%0d", i), 32'(open_m), 32'(v[15:12]));
      check($sformatf("R3 bank vec%0d", i), 32'(bank), 32'(v[32:31]));
      if (v[11]) check($sformatf("R3 R4 row vec%0d", i), 32'(row), 32'(v[10:0]));
      if (v[19:17] == 3'd2 || v[19:17] == 3'd3) begin
        check($sformatf("R4 col vec%0d", i), 32'(col), 32'(v[27:20]));
        check($sformatf("R4 ap vec%0d", i), 32'(auto_pre), 32'(v[30]));
      end
      if (v[19:17] == 3'd4) check($sformatf("R5 all vec%0d", i), 32'(pre_all), 32'(v[30]));
    end

    // Reset clears an open bank
    drive(4'b0011, 2'd3, 11'h123);
    check("R3 open before reset", 32'(open_m), 32'h8);
    do_reset();
    check("R10 open after reset", 32'(open_m), 32'd0);

    // Illegal access starts no burst
    drive(4'b0101, 2'd0, 11'h001);
    check("R7 rd closed illegal", 32'(illegal), 32'd1);
    check("R7 rd closed no burst", 32'(burst), 32'd0);

    // Mode opcode capture and hold
    drive(4'b0000, 2'd0, 11'h233);
    check("R6 cmd", 32'(cmd), 32'd6);
    check("R6 opcode", 32'(mode_op), 32'h233);
    drive(4'b0111, 2'd1, 11'h5AA);
    check("R6 hold", 32'(mode_op), 32'h233);
    drive(4'b0000, 2'd0, 11'h011);
    check("R6 reload", 32'(mode_op), 32'h011);

    // Auto-precharge at burst end, deselects in between
    drive(4'b0011, 2'd2, 11'h055);
    check("R3 open b2", 32'(open_m), 32'h4);
    drive(4'b0101, 2'd2, 11'h405);
    check("R4 ap col", 32'(col), 32'h05);
    check("R4 ap flag", 32'(auto_pre), 32'd1);
    check("R4 ap row", 32'(row), 32'h055);
    check("R8 burst start", 32'(burst), 32'd1);
    drive(4'b1000, 2'd2, 11'h000);
    check("R2 desel cmd", 32'(cmd), 32'd7);
    check("R8 burst runs under deselect", 32'(burst), 32'd1);
    check("R2 state kept", 32'(open_m), 32'h4);
    drive(4'b1000, 2'd0, 11'h000);
    check("R8 burst last beat", 32'(burst), 32'd1);
    check("R9 still open", 32'(open_m), 32'h4);
    drive(4'b1000, 2'd0, 11'h000);
    check("R8 burst done", 32'(burst), 32'd0);
    check("R9 closed at end", 32'(open_m), 32'h0);

    // Interrupting access closes the pending bank early
    drive(4'b0011, 2'd0, 11'h001);
    drive(4'b0011, 2'd1, 11'h002);
    check("R3 two open", 32'(open_m), 32'h3);
    drive(4'b0101, 2'd0, 11'h400);
    check("R9 open during burst", 32'(open_m), 32'h3);
    drive(4'b0100, 2'd1, 11'h010);
    check("R9 closed on interrupt", 32'(open_m), 32'h2);
    check("R8 restart", 32'(burst), 32'd1);
    check("R7 interrupt legal", 32'(illegal), 32'd0);
    repeat (2) drive(4'b0111, 2'd0, 11'h000);
    check("R8 restarted count", 32'(burst), 32'd1);
    drive(4'b0111, 2'd0, 11'h000);
    check("R8 restarted done", 32'(burst), 32'd0);
    check("R9 no ap keeps open", 32'(open_m), 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule